// File: doc/BRIEF.md
# Per-Instruction Pending Request Buffer

This block parks memory access packets that have not yet been merged into line requests. Packets are grouped by the sequence number of the instruction that produced them. Every cycle the block presents work to a downstream merging stage on a small number of lanes. Lane k carries the k-th oldest instruction still held, and on that lane one of the instruction's packets is offered. The downstream stage answers each lane with an accept bit in the same cycle. An accepted packet leaves the buffer at the next clock edge. A refused packet stays where it is and is offered again.

When the last packet of an instruction is accepted, the instruction's slot is released. The block reports one returned credit for that instruction on the same cycle, so that the upstream issuer can send another instruction. The younger instructions then move forward one lane at the next edge.

A side port reports whether a given sequence number still has packets waiting. A sticky error flag rises when any held packet has waited longer than a configured number of cycles. The issuer is expected to assign sequence numbers in increasing order.

Top module: `pend_buf`

## Requirements
- R1: After reset no lane offers a packet, in_ready is 1, tok_cnt is 0, stall_err is 0, and q_done is 1 for any sequence number.
- R2: A packet whose sequence number is already held joins that instruction. A packet with a new sequence number opens a new instruction behind all instructions already held. Each packet slot keeps the address, the write flag and the size.
- R3: Lane k (k = 0 .. WIN-1) offers the k-th oldest held instruction, with its sequence number on off_seq[k*SW +: SW]. When fewer than k+1 instructions are held, lane k is invalid. Valid lanes always form a contiguous group starting at lane 0.
- R4: Within an instruction, packets occupy the lowest free packet slot, and a lane offers the lowest occupied slot. An accepted packet is removed at the next edge, after which the lane offers the next packet. A refused packet stays and is offered again in the following cycle.
- R5: In the cycle where the last packet of an instruction is accepted, tok_cnt counts that instruction, with one credit per drained instruction. At the next edge the younger instructions move forward by one lane for each drained instruction.
- R6: q_done is 0 while any held instruction carries sequence number q_seq, and 1 otherwise. This holds whether or not the instruction is inside the offer window.
- R7: in_ready is 0 when in_seq matches a held instruction whose NPKT packet slots are all used. It is also 0 when in_seq is new and all NINST instruction slots are used. A packet presented while in_ready is 0 is not stored.
- R8: An accept bit on a lane that offers nothing has no effect. No packet is removed and no credit is counted.
- R9: A packet's age is the number of edges since the edge that stored it. stall_err is set at the first edge where some held packet's age exceeds AGE_LIMIT, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Buffer can take the presented packet |
| in_seq | input | SW | Sequence number of the issuing instruction |
| in_addr | input | AW | Packet address |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_size | input | SZW | Packet size code |
| off_valid | output | WIN | Per-lane offer valid |
| off_seq | output | WIN*SW | Per-lane sequence number |
| off_addr | output | WIN*AW | Per-lane offered address |
| off_wr | output | WIN | Per-lane offered write flag |
| off_size | output | WIN*SZW | Per-lane offered size |
| off_acc | input | WIN | Per-lane accept from the merging stage |
| tok_cnt | output | $clog2(NINST+1) | Credits returned this cycle |
| q_seq | input | SW | Sequence number being queried |
| q_done | output | 1 | No packet of q_seq remains |
| stall_err | output | 1 | Sticky over-age flag |

## Verification
Two packets of one instruction are interleaved with single-packet instructions. This separates grouping by sequence number from plain arrival order, and shows whether an instruction beyond the window is still seen by the query. Accepting one lane while refusing the other tells removal apart from retention. Accepting both lanes when only one of them drains checks that credits are counted per drained instruction and not per accepted packet. The buffer is then filled until both kinds of refusal occur, an accept is raised on an empty lane, and a lone packet is left to age across the exact limit cycle.

// File: rtl/pend_buf.sv
module pend_buf #(
  parameter int NINST     = 8,
  parameter int NPKT      = 4,
  parameter int WIN       = 2,
  parameter int AW        = 32,
  parameter int SW        = 16,
  parameter int SZW       = 3,
  parameter int TW        = 16,
  parameter int AGE_LIMIT = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SW-1:0]      in_seq,
  input  logic [AW-1:0]      in_addr,
  input  logic               in_wr,
  input  logic [SZW-1:0]     in_size,
  output logic [WIN-1:0]     off_valid,
  output logic [WIN*SW-1:0]  off_seq,
  output logic [WIN*AW-1:0]  off_addr,
  output logic [WIN-1:0]     off_wr,
  output logic [WIN*SZW-1:0] off_size,
  input  logic [WIN-1:0]     off_acc,
  output logic [$clog2(NINST+1)-1:0] tok_cnt,
  input  logic [SW-1:0]      q_seq,
  output logic               q_done,
  output logic               stall_err
);
  localparam int IW = (NINST > 1) ? $clog2(NINST) : 1;
  localparam int PW = (NPKT > 1) ? $clog2(NPKT) : 1;
  localparam int CW = $clog2(NINST + 1);

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic           wr;
    logic [SZW-1:0] size;
    logic [TW-1:0]  ts;
  } slot_t;

  typedef struct packed {
    logic                v;
    logic [SW-1:0]       seq;
    logic [NPKT-1:0]     pv;
    slot_t [NPKT-1:0]    p;
  } ins_t;

  ins_t q [NINST];
  ins_t t [NINST];
  ins_t d [NINST];

  logic [TW-1:0]  now;
  logic           hit;
  logic [IW-1:0]  hidx;
  logic [CW-1:0]  live;
  logic [PW-1:0]  fz;
  logic [NINST-1:0] keep;
  logic           old;
  logic [PW-1:0]  sel [WIN];

  function automatic logic [PW-1:0] first_one(input logic [NPKT-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPKT - 1; i >= 0; i--)
      if (v[i]) r = PW'(i);
    return r;
  endfunction

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    live = '0;
    for (int i = 0; i < NINST; i++) begin
      if (q[i].v) live = live + CW'(1);
      if (q[i].v && q[i].seq == in_seq) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
    end
  end

  assign fz       = first_one(~q[hidx].pv);
  assign in_ready = hit ? ~&q[hidx].pv : (live < CW'(NINST));

  for (genvar k = 0; k < WIN; k++) begin : g_lane
    assign sel[k]                   = first_one(q[k].pv);
    assign off_valid[k]             = q[k].v && |q[k].pv;
    assign off_seq[k*SW +: SW]      = q[k].seq;
    assign off_addr[k*AW +: AW]     = q[k].p[sel[k]].addr;
    assign off_wr[k]                = q[k].p[sel[k]].wr;
    assign off_size[k*SZW +: SZW]   = q[k].p[sel[k]].size;
  end

  always_comb begin
    for (int i = 0; i < NINST; i++) t[i] = q[i];
    for (int k = 0; k < WIN; k++)
      if (off_valid[k] && off_acc[k]) t[k].pv[sel[k]] = 1'b0;
    if (in_valid && in_ready) begin
      if (hit) begin
        t[hidx].pv[fz] = 1'b1;
        t[hidx].p[fz]  = {in_addr, in_wr, in_size, now};
      end else begin
        t[live[IW-1:0]].v    = 1'b1;
        t[live[IW-1:0]].seq  = in_seq;
        t[live[IW-1:0]].pv   = NPKT'(1);
        t[live[IW-1:0]].p[0] = {in_addr, in_wr, in_size, now};
      end
    end
  end

  always_comb begin
    tok_cnt = '0;
    for (int i = 0; i < NINST; i++) begin
      keep[i] = t[i].v && |t[i].pv;
      if (q[i].v && !keep[i]) tok_cnt = tok_cnt + CW'(1);
    end
  end

  always_comb begin
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < NINST; i++) d[i] = '0;
    for (int i = 0; i < NINST; i++)
      if (keep[i]) begin
        d[r[IW-1:0]] = t[i];
        r = r + CW'(1);
      end
  end

  always_comb begin
    logic [TW-1:0] age;
    old = 1'b0;
    for (int i = 0; i < NINST; i++)
      for (int j = 0; j < NPKT; j++) begin
        age = now - q[i].p[j].ts;
        if (q[i].v && q[i].pv[j] && age > TW'(AGE_LIMIT)) old = 1'b1;
      end
  end

  always_comb begin
    q_done = 1'b1;
    for (int i = 0; i < NINST; i++)
      if (q[i].v && q[i].seq == q_seq) q_done = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NINST; i++) q[i] <= '0;
      now       <= '0;
      stall_err <= 1'b0;
    end else begin
      for (int i = 0; i < NINST; i++) q[i] <= d[i];
      now       <= now + TW'(1);
      stall_err <= stall_err | old;
    end
  end
endmodule

// File: rtl/pend_buf_chk.sv
module pend_buf_chk #(
  parameter int WIN = 2,
  parameter int SW  = 16,
  parameter int CW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIN-1:0]    off_valid,
  input logic [WIN-1:0]    off_acc,
  input logic [WIN*SW-1:0] off_seq,
  input logic [CW-1:0]     tok_cnt,
  input logic [SW-1:0]     q_seq,
  input logic              q_done,
  input logic              stall_err
);
  a_r3_window_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((off_valid >> 1) & ~off_valid) == '0);

  a_r5_tok_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tok_cnt) <= $countones(off_valid & off_acc));

  a_r6_offered_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    (off_valid[0] && q_seq == off_seq[SW-1:0]) |-> !q_done);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stall_err |=> stall_err);
endmodule

bind pend_buf pend_buf_chk #(.WIN(WIN), .SW(SW), .CW($clog2(NINST+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .off_valid(off_valid), .off_acc(off_acc),
  .off_seq(off_seq), .tok_cnt(tok_cnt), .q_seq(q_seq), .q_done(q_done),
  .stall_err(stall_err)
);

// File: tb/test_pend_buf.sv
`timescale 1ns/1ps
module test_pend_buf;
  localparam int NINST = 4, NPKT = 3, WIN = 2, AW = 16, SW = 8, SZW = 3;
  localparam int TW = 12, AGE = 60, CW = $clog2(NINST+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SW-1:0] in_seq = '0;
  logic [AW-1:0] in_addr = '0;
  logic in_wr = 1'b0;
  logic [SZW-1:0] in_size = '0;
  logic [WIN-1:0] off_valid;
  logic [WIN*SW-1:0] off_seq;
  logic [WIN*AW-1:0] off_addr;
  logic [WIN-1:0] off_wr;
  logic [WIN*SZW-1:0] off_size;
  logic [WIN-1:0] off_acc = '0;
  logic [CW-1:0] tok_cnt;
  logic [SW-1:0] q_seq = '0;
  logic q_done;
  logic stall_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pend_buf #(.NINST(NINST), .NPKT(NPKT), .WIN(WIN), .AW(AW), .SW(SW), .SZW(SZW),
             .TW(TW), .AGE_LIMIT(AGE)) i_pend_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_seq(in_seq), .in_addr(in_addr), .in_wr(in_wr), .in_size(in_size),
    .off_valid(off_valid), .off_seq(off_seq), .off_addr(off_addr),
    .off_wr(off_wr), .off_size(off_size), .off_acc(off_acc),
    .tok_cnt(tok_cnt), .q_seq(q_seq), .q_done(q_done), .stall_err(stall_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int lseq(input int k);  return int'(off_seq[k*SW +: SW]); endfunction
  function automatic int laddr(input int k); return int'(off_addr[k*AW +: AW]); endfunction

  task automatic push(input int s, input int a, input bit w, input int sz);
    @(negedge clk);
    in_valid = 1'b1; in_seq = SW'(s); in_addr = AW'(a); in_wr = w; in_size = SZW'(sz);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic query(input int s, input string req, input int exp);
    q_seq = SW'(s); #1;
    chk(req, int'(q_done), exp);
  endtask

  task automatic step_acc(input logic [WIN-1:0] a, input string req, input int exp_tok);
    @(negedge clk);
    off_acc = a; #1;
    chk(req, int'(tok_cnt), exp_tok);
    @(negedge clk);
    off_acc = '0; #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
  endtask

  task automatic t_reset();
    chk("R1 no offers", int'(off_valid), 0);
    chk("R1 ready", int'(in_ready), 1);
    chk("R1 tok", int'(tok_cnt), 0);
    chk("R1 err", int'(stall_err), 0);
    query(8'h33, "R1 done", 1);
  endtask

  task automatic t_group();
    push(5, 'h100, 0, 2);
    push(5, 'h104, 1, 2);
    push(7, 'h200, 0, 1);
    push(9, 'h300, 1, 3);
    chk("R3 both lanes", int'(off_valid), 3);
    chk("R2 lane0 seq", lseq(0), 5);
    chk("R2 lane0 addr", laddr(0), 'h100);
    chk("R2 lane0 size", int'(off_size[SZW-1:0]), 2);
    chk("R3 lane1 seq", lseq(1), 7);
    chk("R2 lane1 addr", laddr(1), 'h200);
    query(5, "R6 held", 0);
    query(9, "R6 outside window", 0);
    query(6, "R6 absent", 1);
  endtask

  task automatic t_drain();
    step_acc(2'b01, "R5 partial no tok", 0);
    chk("R4 next packet addr", laddr(0), 'h104);
    chk("R4 next packet wr", int'(off_wr[0]), 1);
    chk("R4 refused stays", laddr(1), 'h200);
    step_acc(2'b01, "R5 drain tok", 1);
    chk("R5 shift lane0", lseq(0), 7);
    chk("R5 shift lane1", lseq(1), 9);
    chk("R5 shift lane1 addr", laddr(1), 'h300);
    query(5, "R6 drained", 1);
  endtask

  task automatic t_ignore();
    step_acc(2'b01, "R5 drain seq7", 1);
    chk("R3 one lane", int'(off_valid), 1);
    step_acc(2'b10, "R8 empty lane no tok", 0);
    chk("R8 still one lane", int'(off_valid), 1);
    chk("R8 packet kept", laddr(0), 'h300);
  endtask

  task automatic t_full();
    push(9, 'h304, 0, 1);
    push(9, 'h308, 0, 1);
    in_seq = 8'd9; #1;
    chk("R7 instruction full", int'(in_ready), 0);
    push(10, 'h400, 0, 1);
    push(11, 'h500, 0, 1);
    push(12, 'h600, 0, 1);
    in_seq = 8'd13; #1;
    chk("R7 slots full", int'(in_ready), 0);
    push(13, 'h700, 0, 1);
    query(13, "R7 refused not stored", 1);
    chk("R3 lane1 seq10", lseq(1), 10);
  endtask

  task automatic t_pair();
    step_acc(2'b11, "R5 one of two drains", 1);
    chk("R4 lane0 next", laddr(0), 'h304);
    chk("R5 lane1 moved", lseq(1), 11);
    chk("R9 no early err", int'(stall_err), 0);
  endtask

  task automatic t_age();
    do_reset();
    chk("R1 err cleared", int'(stall_err), 0);
    push(20, 'h800, 1, 0);
    repeat (AGE) @(negedge clk);
    #1;
    chk("R9 at limit", int'(stall_err), 0);
    @(negedge clk); #1;
    chk("R9 past limit", int'(stall_err), 1);
    @(negedge clk); #1;
    chk("R9 sticky", int'(stall_err), 1);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_group();
    t_drain();
    t_ignore();
    t_full();
    t_pair();
    t_age();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule